// File: doc/BRIEF.md
# Alarm, Watchdog and Wake Supervisor

This block watches over a host processor and drives three lines: an interrupt request, a reset, and a power-enable that can switch on a system supply. Three kinds of event feed it. The first is a time-of-day or calendar alarm. It is formed by comparing the current BCD time, supplied from an external clock counter, against host-programmed alarm fields. The second is expiry of a host-programmed watchdog down-counter that advances on an external tick. The third is the rising edge of an already debounced kickstart input, such as a key closure.

Every event sets a sticky flag that the host clears by writing a one. A steering register decides, per event source, whether the flag raises the interrupt and whether the event fires a fixed-length reset pulse. Kickstart and alarm events can also set a power-enable latch, which software clears once its work is done. A power-good input forces the reset output active while power is bad. Reset stays active for a settle time after power returns.

Reset sequencing is a four-state machine. RS_OFF holds reset while power is bad. RS_SETTLE counts the settle time after power returns. RS_RUN is the only state with reset released. RS_PULSE times a routed reset pulse. The transitions are: OFF to SETTLE when power is good; SETTLE to RUN when the settle count ends; RUN to PULSE on a routed event; PULSE to RUN when the pulse count ends; and SETTLE, RUN or PULSE back to OFF whenever power goes bad.

Top module: `wake_supervisor`

## Requirements
- R1: After `rst_n` is released, `rst_out` is 1, `irq_out` and `pwr_en_out` are 0, and every host address reads 0.
- R2: `rst_out` is 1 in the cycle after any cycle with `pwr_good` low, and stays 1 while it is low. An active reset pulse is abandoned. Reset is released exactly HOLD_CYCLES clocks after the first clock edge that samples `pwr_good` high.
- R3: Alarm fields are BCD bytes: seconds at address 0, minutes at 1, hours at 2 and day at 3. Address 4 bits 0..3 mask seconds, minutes, hours and day, and a masked field always matches. Address 4 bit 4 compares the day field against `tod_dow` when 1 and against `tod_date` when 0. The alarm matches when every field matches.
- R4: An alarm event occurs only on a cycle where the match becomes true after being false. It sets flag bit 0 (address 9) at the next clock edge. A match that stays true raises no further event.
- R5: Writing address 5 loads both the reload value and the counter. The watchdog expires on the Nth `wd_tick` after a write of N, sets flag bit 1, and restarts with the same period. A rewrite restarts the count. A value of 0 stops it. The counter stays at its reload value while `rst_out` is 1.
- R6: A rising edge of `kick_in` sets flag bit 2.
- R7: Writing address 9 clears each flag whose data bit is 1 and leaves the others alone. An event in the same cycle as the clear of its own flag leaves that flag set.
- R8: `irq_out` is 1 while any flag is set whose interrupt enable is set. The enables are address 6 bits 0, 1 and 2 for alarm, watchdog and kickstart.
- R9: Address 6 bits 3, 4 and 5 route alarm, watchdog and kickstart events to reset. A routed event in RS_RUN drives `rst_out` to 1 for exactly PULSE_CYCLES clocks, starting the next cycle. Further events during the pulse do not lengthen it. Unrouted events leave `rst_out` at 0.
- R10: With address 7 bit 0 set a kickstart event sets `pwr_en_out` at the next edge, and with bit 1 set an alarm event does. The output stays set until a write to address 8 with data bit 0 equal to 1. Writes with bit 0 equal to 0 do not clear it. Address 8 reads the latch in bit 0.
- R11: Addresses 0..3 and 5 read back the full written byte. Address 4 reads bits 4..0, address 6 reads bits 5..0 and address 7 reads bits 1..0, with the other bits 0. Addresses 10..15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply is valid (synchronous) |
| kick_in | input | 1 | Debounced kickstart level |
| wd_tick | input | 1 | Watchdog time-base strobe |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| tod_dow | input | 8 | Current day of week, BCD |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| irq_out | output | 1 | Interrupt request, active high |
| rst_out | output | 1 | Host reset, active high |
| pwr_en_out | output | 1 | Power-enable latch |

## Verification
The hardest condition to reach from the ports is an alarm event under each mask and day-mode combination. An event needs a false-to-true change of the match, and a fully masked alarm matches all the time, so a naive stimulus never shows the edge. The bench handles this in a fixed order. It first parks the time on values that miss every field. It waits until the change of mask has settled, clears the flags, and only then applies a time in which a chosen subset of fields is equal. This covers all 512 combinations of mask, day mode and field equality. A second hard case is a power loss in the middle of a reset pulse. The bench times the drop of `pwr_good` while the pulse is still running and checks that the settle count, not the leftover pulse, decides the release.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int N_FIELDS = 4;
    localparam int N_EVT    = 3;

    localparam int EV_ALARM = 0;
    localparam int EV_WDOG  = 1;
    localparam int EV_KICK  = 2;

    localparam logic [ADDR_W-1:0] AD_ACTRL  = 4'd4;
    localparam logic [ADDR_W-1:0] AD_WDOG   = 4'd5;
    localparam logic [ADDR_W-1:0] AD_ROUTE  = 4'd6;
    localparam logic [ADDR_W-1:0] AD_WAKE   = 4'd7;
    localparam logic [ADDR_W-1:0] AD_PWRCLR = 4'd8;
    localparam logic [ADDR_W-1:0] AD_FLAGS  = 4'd9;

    typedef enum logic [1:0] {
        RS_OFF,
        RS_SETTLE,
        RS_RUN,
        RS_PULSE
    } rst_state_t;

endpackage

// File: rtl/sup_alarm_match.sv
module sup_alarm_match #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [N*W-1:0] now_flat,
    input  logic [N*W-1:0] alm_flat,
    input  logic [N-1:0]   mask,
    output logic           match
);

    logic [N-1:0] field_ok;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_field
            assign field_ok[g] = mask[g] || (now_flat[g*W +: W] == alm_flat[g*W +: W]);
        end
    endgenerate

    assign match = &field_ok;

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         hold,
    output logic         expire,
    output logic [W-1:0] count,
    output logic [W-1:0] reload
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] count_q;
    logic [W-1:0] reload_q;

    always_comb begin
        expire = tick && !hold && (reload_q != ZERO) && (count_q == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= ZERO;
            reload_q <= ZERO;
        end else if (load) begin
            count_q  <= load_val;
            reload_q <= load_val;
        end else if (hold || expire) begin
            count_q  <= reload_q;
        end else if (tick && (reload_q != ZERO)) begin
            count_q  <= count_q - ONE;
        end
    end

    assign count  = count_q;
    assign reload = reload_q;

endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
    import sup_pkg::*;
#(
    parameter int HOLD_CYCLES  = 16,
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic pulse_req,
    output logic rst_out
);

    localparam int MAXC  = (HOLD_CYCLES > PULSE_CYCLES) ? HOLD_CYCLES : PULSE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYCLES - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    rst_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CNT_ONE;
        unique case (state_q)
            RS_OFF: begin
                cnt_d = '0;
                if (pwr_good) state_d = RS_SETTLE;
            end
            RS_SETTLE: begin
                if (!pwr_good) begin
                    state_d = RS_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == HOLD_LAST) begin
                    state_d = RS_RUN;
                    cnt_d   = '0;
                end
            end
            RS_RUN: begin
                cnt_d = '0;
                if (!pwr_good)      state_d = RS_OFF;
                else if (pulse_req) state_d = RS_PULSE;
            end
            RS_PULSE: begin
                if (!pwr_good) begin
                    state_d = RS_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == PULSE_LAST) begin
                    state_d = RS_RUN;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = RS_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        rst_out = (state_q != RS_RUN);
    end

endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor
    import sup_pkg::*;
#(
    parameter int HOLD_CYCLES  = 16,
    parameter int PULSE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              kick_in,
    input  logic              wd_tick,
    input  logic [7:0]        tod_sec,
    input  logic [7:0]        tod_min,
    input  logic [7:0]        tod_hour,
    input  logic [7:0]        tod_date,
    input  logic [7:0]        tod_dow,
    input  logic              host_we,
    input  logic [3:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq_out,
    output logic              rst_out,
    output logic              pwr_en_out
);

    localparam int W  = DATA_W;
    localparam int NF = N_FIELDS;
    localparam int NE = N_EVT;

    logic [W-1:0]    alm_q [NF];
    logic [NF:0]     actrl_q;
    logic [2*NE-1:0] route_q;
    logic [1:0]      wake_q;
    logic [NE-1:0]   flags_q;
    logic            pwr_en_q;
    logic            match_q;
    logic            kick_q;

    logic [NF*W-1:0] now_flat;
    logic [NF*W-1:0] alm_flat;
    logic [W-1:0]    day_sel;
    logic            match_now;
    logic            alarm_evt;
    logic            kick_evt;
    logic            wd_expire;
    logic            wd_load;
    logic [W-1:0]    wd_count;
    logic [W-1:0]    wd_reload;
    logic [NE-1:0]   evt_vec;
    logic [NE-1:0]   flag_clr;
    logic            pwr_clr;
    logic            pwr_set;
    logic            pulse_req;

    // alarm comparison
    assign day_sel  = actrl_q[NF] ? tod_dow : tod_date;
    assign now_flat = {day_sel, tod_hour, tod_min, tod_sec};

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_alm
            assign alm_flat[g*W +: W] = alm_q[g];
        end
    endgenerate

    sup_alarm_match #(.W(W), .N(NF)) i_match (
        .now_flat (now_flat),
        .alm_flat (alm_flat),
        .mask     (actrl_q[NF-1:0]),
        .match    (match_now)
    );

    // watchdog
    assign wd_load = host_we && (host_addr == AD_WDOG);

    sup_watchdog #(.W(W)) i_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wd_load),
        .load_val (host_wdata),
        .tick     (wd_tick),
        .hold     (rst_out),
        .expire   (wd_expire),
        .count    (wd_count),
        .reload   (wd_reload)
    );

    // event detection and steering
    assign alarm_evt = match_now && !match_q;
    assign kick_evt  = kick_in && !kick_q;

    always_comb begin
        evt_vec           = '0;
        evt_vec[EV_ALARM] = alarm_evt;
        evt_vec[EV_WDOG]  = wd_expire;
        evt_vec[EV_KICK]  = kick_evt;
    end

    assign flag_clr  = (host_we && (host_addr == AD_FLAGS)) ? host_wdata[NE-1:0] : '0;
    assign pwr_clr   = host_we && (host_addr == AD_PWRCLR) && host_wdata[0];
    assign pwr_set   = (kick_evt && wake_q[0]) || (alarm_evt && wake_q[1]);
    assign pulse_req = |(evt_vec & route_q[2*NE-1:NE]);

    sup_reset_seq #(
        .HOLD_CYCLES  (HOLD_CYCLES),
        .PULSE_CYCLES (PULSE_CYCLES)
    ) i_rseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .pulse_req (pulse_req),
        .rst_out   (rst_out)
    );

    // host registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NF; i++) alm_q[i] <= '0;
            actrl_q <= '0;
            route_q <= '0;
            wake_q  <= '0;
        end else if (host_we) begin
            for (int i = 0; i < NF; i++) begin
                if (host_addr == ADDR_W'(i)) alm_q[i] <= host_wdata;
            end
            if (host_addr == AD_ACTRL) actrl_q <= host_wdata[NF:0];
            if (host_addr == AD_ROUTE) route_q <= host_wdata[2*NE-1:0];
            if (host_addr == AD_WAKE)  wake_q  <= host_wdata[1:0];
        end
    end

    // flags, edge history and power latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q  <= '0;
            pwr_en_q <= 1'b0;
            match_q  <= 1'b1;
            kick_q   <= 1'b0;
        end else begin
            flags_q  <= (flags_q & ~flag_clr) | evt_vec;
            pwr_en_q <= pwr_set || (pwr_en_q && !pwr_clr);
            match_q  <= match_now;
            kick_q   <= kick_in;
        end
    end

    // read mux
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NF; i++) begin
            if (host_addr == ADDR_W'(i)) host_rdata = alm_q[i];
        end
        case (host_addr)
            AD_ACTRL:  host_rdata = W'(actrl_q);
            AD_WDOG:   host_rdata = wd_reload;
            AD_ROUTE:  host_rdata = W'(route_q);
            AD_WAKE:   host_rdata = W'(wake_q);
            AD_PWRCLR: host_rdata = W'(pwr_en_q);
            AD_FLAGS:  host_rdata = W'(flags_q);
            default:   ;
        endcase
    end

    assign irq_out    = |(flags_q & route_q[NE-1:0]);
    assign pwr_en_out = pwr_en_q;

endmodule

// File: rtl/sup_checker.sv
module sup_checker
    import sup_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_good,
    input logic              rst_out,
    input logic              irq_out,
    input logic              pwr_en_out,
    input logic              pwr_clr,
    input logic              kick_evt,
    input logic              kick_irq_en,
    input logic              wd_expire,
    input logic [DATA_W-1:0] wd_count,
    input logic [DATA_W-1:0] wd_reload,
    input logic              pulse_req
);

    // R2
    pwr_loss_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> rst_out);

    // R8
    kick_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_evt && kick_irq_en) |=> irq_out);

    // R10
    pwr_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_out) |-> $past(pwr_clr));

    // R9
    rst_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(!pwr_good || pulse_req));

    // R5
    wd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> (wd_count == wd_reload));

endmodule

bind wake_supervisor sup_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .rst_out     (rst_out),
    .irq_out     (irq_out),
    .pwr_en_out  (pwr_en_out),
    .pwr_clr     (pwr_clr),
    .kick_evt    (kick_evt),
    .kick_irq_en (route_q[2]),
    .wd_expire   (wd_expire),
    .wd_count    (wd_count),
    .wd_reload   (wd_reload),
    .pulse_req   (pulse_req)
);

// File: tb/test_wake_supervisor.sv
module test_wake_supervisor;

    localparam int HOLD  = 16;
    localparam int PULSE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       kick_in = 1'b0;
    logic       wd_tick = 1'b0;
    logic [7:0] tod_sec = 8'h31, tod_min = 8'h16, tod_hour = 8'h09;
    logic [7:0] tod_date = 8'h06, tod_dow = 8'h06;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = 4'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       irq_out, rst_out, pwr_en_out;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    wake_supervisor #(.HOLD_CYCLES(HOLD), .PULSE_CYCLES(PULSE)) i_wake_supervisor (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .kick_in(kick_in),
        .wd_tick(wd_tick), .tod_sec(tod_sec), .tod_min(tod_min),
        .tod_hour(tod_hour), .tod_date(tod_date), .tod_dow(tod_dow),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_out(irq_out), .rst_out(rst_out),
        .pwr_en_out(pwr_en_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic time_miss();
        tod_sec = 8'h31; tod_min = 8'h16; tod_hour = 8'h09;
        tod_date = 8'h06; tod_dow = 8'h06;
    endtask

    task automatic time_hit();
        tod_sec = 8'h30; tod_min = 8'h15; tod_hour = 8'h08;
        tod_date = 8'h05; tod_dow = 8'h05;
    endtask

    // src 0 alarm (ctrl must be 0), 1 watchdog, 2 kickstart
    task automatic fire(input int src);
        case (src)
            0: begin
                time_miss(); idle(2);
                time_hit(); @(negedge clk);
            end
            1: begin
                wr(4'd5, 8'd1);
                wd_tick = 1'b1; @(negedge clk); wd_tick = 1'b0;
            end
            default: begin
                kick_in = 1'b1; @(negedge clk); kick_in = 1'b0;
            end
        endcase
    endtask

    task automatic count_rst(output int n);
        n = 0;
        while (rst_out && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, m;

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 rst_out", rst_out, 1);
        chk("R1 irq_out", irq_out, 0);
        chk("R1 pwr_en_out", pwr_en_out, 0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk("R1 readback zero", v, 0);
        end
        // R2 held while power bad, then settle count
        idle(5);
        chk("R2 held while pwr bad", rst_out, 1);
        pwr_good = 1'b1;
        @(negedge clk);
        count_rst(n);
        chk("R2 settle length", n, HOLD);

        // R11 readback sweep
        for (int a = 0; a < 8; a++) begin
            for (int d = 0; d < 256; d++) begin
                logic [7:0] msk;
                msk = (a == 4) ? 8'h1F : (a == 6) ? 8'h3F : (a == 7) ? 8'h03 : 8'hFF;
                wr(4'(a), 8'(d));
                rd(4'(a), v);
                chk("R11 readback", v, 8'(d) & msk);
            end
        end
        for (int a = 10; a < 16; a++) begin
            wr(4'(a), 8'hFF);
            rd(4'(a), v);
            chk("R11 unused addr", v, 0);
        end
        wr(4'd5, 8'd0); wr(4'd6, 8'd0); wr(4'd7, 8'd0);
        wr(4'd0, 8'h30); wr(4'd1, 8'h15); wr(4'd2, 8'h08); wr(4'd3, 8'h05);

        // R3 R4 alarm sweep: mask x day mode x equal-field pattern
        for (int md = 0; md < 32; md++) begin
            for (int e = 0; e < 16; e++) begin
                logic [3:0] mk;
                bit dmode, pre, hit;
                mk = 4'(md); dmode = md[4];
                time_miss();
                wr(4'd4, 8'(md));
                idle(1);
                wr(4'd9, 8'h07);
                tod_sec  = e[0] ? 8'h30 : 8'h31;
                tod_min  = e[1] ? 8'h15 : 8'h16;
                tod_hour = e[2] ? 8'h08 : 8'h09;
                if (dmode) begin
                    tod_dow = e[3] ? 8'h05 : 8'h06; tod_date = e[3] ? 8'h06 : 8'h05;
                end else begin
                    tod_date = e[3] ? 8'h05 : 8'h06; tod_dow = e[3] ? 8'h06 : 8'h05;
                end
                idle(1);
                pre = (mk == 4'hF);
                hit = &(mk | 4'(e));
                rd(4'd9, v);
                chk("R3 R4 alarm flag", v[0], hit && !pre);
            end
        end
        wr(4'd4, 8'h00);
        // R4 steady match raises no new event
        fire(0);
        wr(4'd9, 8'h07);
        idle(3);
        rd(4'd9, v);
        chk("R4 no repeat on steady match", v[0], 0);

        // R5 watchdog period and restart
        for (int k = 1; k < 14; k++) begin
            int per;
            per = (k == 13) ? 255 : k;
            wr(4'd9, 8'h07);
            wr(4'd5, 8'(per));
            for (int rep = 0; rep < 2; rep++) begin
                n = 0;
                v = 0;
                while (!v[1] && n < 300) begin
                    wd_tick = 1'b1; @(negedge clk); n++;
                    rd(4'd9, v);
                end
                wd_tick = 1'b0;
                chk("R5 watchdog period", n, per);
                wr(4'd9, 8'h02);
            end
        end
        wr(4'd5, 8'd0);
        wr(4'd9, 8'h07);
        wd_tick = 1'b1; idle(40); wd_tick = 1'b0;
        rd(4'd9, v);
        chk("R5 zero disables", v[1], 0);
        wr(4'd5, 8'd3);
        wd_tick = 1'b1; idle(2); wd_tick = 1'b0;
        wr(4'd5, 8'd3);
        wd_tick = 1'b1; idle(2); wd_tick = 1'b0;
        rd(4'd9, v);
        chk("R5 rewrite restarts", v[1], 0);
        wd_tick = 1'b1; idle(1); wd_tick = 1'b0;
        rd(4'd9, v);
        chk("R5 expiry after restart", v[1], 1);
        wr(4'd5, 8'd0);

        // R6 kickstart edge only
        wr(4'd9, 8'h07);
        kick_in = 1'b1; idle(1);
        rd(4'd9, v);
        chk("R6 kick flag", v[2], 1);
        wr(4'd9, 8'h04);
        idle(3);
        rd(4'd9, v);
        chk("R6 held level no new event", v[2], 0);
        kick_in = 1'b0; idle(1);

        // R7 clear selectivity and set-wins
        fire(0); fire(2);
        wr(4'd9, 8'h04);
        rd(4'd9, v);
        chk("R7 selective clear", v, 8'h01);
        host_we = 1'b1; host_addr = 4'd9; host_wdata = 8'h04; kick_in = 1'b1;
        @(negedge clk);
        host_we = 1'b0; kick_in = 1'b0;
        rd(4'd9, v);
        chk("R7 set wins over clear", v, 8'h05);

        // R8 interrupt steering
        for (int en = 0; en < 8; en++) begin
            for (int src = 0; src < 3; src++) begin
                wr(4'd6, 8'(en));
                wr(4'd9, 8'h07);
                #1 chk("R8 irq low after clear", irq_out, 0);
                fire(src);
                #1 chk("R8 irq steering", irq_out, en[src]);
                rd(4'd9, v);
                chk("R8 flag source", v, 8'(1 << src));
            end
        end
        wr(4'd6, 8'h00); wr(4'd9, 8'h07); wr(4'd5, 8'd0);

        // R9 reset steering
        for (int src = 0; src < 3; src++) begin
            wr(4'd6, 8'(1 << (3 + src)));
            fire(src);
            count_rst(n);
            chk("R9 pulse length", n, PULSE);
            wr(4'd6, 8'h07);
            fire(src);
            count_rst(n);
            chk("R9 unrouted no pulse", n, 0);
        end
        wr(4'd5, 8'd0);
        wr(4'd6, 8'h20);
        fire(2);
        kick_in = 1'b1; @(negedge clk); kick_in = 1'b0;
        count_rst(m);
        chk("R9 pulse not extended", 1 + m, PULSE);

        // R2 power loss during pulse and from run
        fire(2);
        idle(2);
        pwr_good = 1'b0; @(negedge clk);
        chk("R2 loss asserts reset", rst_out, 1);
        idle(3);
        chk("R2 stays during loss", rst_out, 1);
        pwr_good = 1'b1; @(negedge clk);
        count_rst(n);
        chk("R2 settle after aborted pulse", n, HOLD);
        wr(4'd6, 8'h00);
        pwr_good = 1'b0; @(negedge clk);
        chk("R2 loss from run", rst_out, 1);
        pwr_good = 1'b1; @(negedge clk);
        count_rst(n);
        chk("R2 settle after loss", n, HOLD);

        // R10 power latch
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int s = 0; s < 2; s++) begin
                int src;
                bit exp;
                src = (s == 0) ? 0 : 2;
                exp = (src == 2) ? cfg[0] : cfg[1];
                wr(4'd7, 8'(cfg));
                wr(4'd8, 8'h01);
                #1 chk("R10 cleared", pwr_en_out, 0);
                fire(src);
                #1 chk("R10 wake set", pwr_en_out, exp);
                rd(4'd8, v);
                chk("R10 readback", v, 8'(exp));
            end
        end
        wr(4'd7, 8'h01);
        fire(2);
        wr(4'd8, 8'h00);
        wr(4'd8, 8'hFE);
        #1 chk("R10 bit0 zero keeps latch", pwr_en_out, 1);
        wr(4'd8, 8'h01);
        #1 chk("R10 clear", pwr_en_out, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule